// File: doc/BRIEF.md
# Asynchronous Serial Transmit Path

This block is the transmit half of an asynchronous serial port. A processor writes a byte into a one-entry data holding register. When the transmitter is enabled and the line is idle, the block shifts the byte out as one frame on a single output line. The frame is a low start bit, the data bits with the least significant bit first, an optional ninth data bit, and a high stop bit. The line rests high between frames.

Bit timing comes from a one-cycle `bit_tick` pulse supplied by an external baud-rate generator. Each frame bit stays on the line until the next tick.

Two status flags show the state of the transmitter: data-register-empty and transmission-complete. They fall together in the edge that starts a frame and rise together in the edge of the tick that ends it. While the empty flag is low, writes to the data register are discarded. Each flag has its own interrupt enable, and the two enabled flags are combined into one interrupt request line.

Top module: `sertx_unit`

## Requirements
- R1: After reset, `flag_empty` and `flag_done` are both 1, `txd` is 1, and no byte is held. Setting `tx_en` without any write starts no frame.
- R2: A write (`wr_en` high at a clock edge) is accepted only if `flag_empty` is 1 before that edge. A write made while a frame is in progress, including one in the cycle of the frame's final tick, leaves the frame unchanged and is never sent.
- R3: A write accepted while `tx_en` is 1 and the line is idle starts a frame in that same edge. After that edge, both flags are 0 and `txd` shows the start bit (0).
- R4: `flag_empty` and `flag_done` always hold the same value. Both fall when a frame starts and both rise when it ends.
- R5: A frame ends on the 10th `bit_tick` after its start when `len9` is 0, and on the 11th when `len9` is 1. `txd` and the flags change only on tick edges while a frame runs.
- R6: Bit k of the frame is driven from tick k to tick k+1, with the start at k=0. Frame bit 0 is 0. Bits 1 to 8 are data bits 0 to 7. In 9-bit mode, bit 9 is the value of `bit9` captured at frame start, and the last bit is the stop bit (1).
- R7: A write accepted while `tx_en` is 0 keeps the byte pending, and both flags stay 1. A later write replaces the pending byte. Raising `tx_en` then starts a frame with the latest byte in that edge.
- R8: `irq` equals (`flag_empty` AND `irq_empty_en`) OR (`flag_done` AND `irq_done_en`).
- R9: `txd` is 1 whenever no frame is in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the data register |
| wr_data | input | 8 | Byte to transmit |
| tx_en | input | 1 | Transmitter enable |
| len9 | input | 1 | Character length: 0 = 8 data bits, 1 = 9 data bits |
| bit9 | input | 1 | Ninth data bit, captured at frame start |
| irq_empty_en | input | 1 | Interrupt enable for the empty flag |
| irq_done_en | input | 1 | Interrupt enable for the complete flag |
| bit_tick | input | 1 | One-cycle bit-period pulse from the baud generator |
| txd | output | 1 | Serial line, idle high |
| flag_empty | output | 1 | Data register empty |
| flag_done | output | 1 | Transmission complete |
| irq | output | 1 | Combined interrupt request |

## Verification
Two pairs of events can fall in the same cycle.

- A processor write can arrive in the cycle of the tick that ends a frame. The bench places such a write on the final tick in some random frames and then expects the line and both flags to stay idle for several more ticks. That proves the write was judged against the flags as they stood before the edge.
- A write can land in the same edge that finds the line idle and enabled, or the enable can rise while a byte is pending. In both cases the bench expects the start bit and both flags low right after that single edge, and then expects a frame made from the latest byte accepted.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

    localparam int SERTX_DATA_W = 8;

    // control state of the holding register and the status flags
    typedef struct packed {
        logic empty;
        logic done;
        logic pend;
    } sertx_flags_t;

endpackage

// File: rtl/sertx_frame_pack.sv
module sertx_frame_pack #(
    parameter int DATA_W = 8,
    localparam int FW    = DATA_W + 3,
    localparam int CW    = $clog2(DATA_W + 4)
) (
    input  logic [DATA_W-1:0] data,
    input  logic              len9,
    input  logic              bit9,
    output logic [FW-1:0]     word,
    output logic [CW-1:0]     nbits
);
    // bit 0 start, data LSB first, optional ninth bit, stop; unused top bit is 1
    always_comb begin
        word  = {1'b1, (len9 ? bit9 : 1'b1), data, 1'b0};
        nbits = len9 ? CW'(DATA_W + 3) : CW'(DATA_W + 2);
    end
endmodule

// File: rtl/sertx_shifter.sv
module sertx_shifter #(
    parameter int DATA_W = 8,
    localparam int FW    = DATA_W + 3,
    localparam int CW    = $clog2(DATA_W + 4)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [FW-1:0] load_word,
    input  logic [CW-1:0] load_nbits,
    input  logic          tick,
    output logic          line,
    output logic          busy,
    output logic          frame_end
);
    typedef struct packed {
        logic [FW-1:0] sh;
        logic [CW-1:0] cnt;
        logic [CW-1:0] nbits;
        logic          busy;
    } shift_t;

    shift_t s_d, s_q;

    always_comb begin
        frame_end = s_q.busy && tick && (s_q.cnt == s_q.nbits - CW'(1));
        s_d       = s_q;
        if (load) begin
            s_d.sh    = load_word;
            s_d.cnt   = '0;
            s_d.nbits = load_nbits;
            s_d.busy  = 1'b1;
        end else if (frame_end) begin
            s_d.sh   = '1;
            s_d.cnt  = '0;
            s_d.busy = 1'b0;
        end else if (s_q.busy && tick) begin
            s_d.sh  = {1'b1, s_q.sh[FW-1:1]};
            s_d.cnt = s_q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.sh    <= '1;
            s_q.cnt   <= '0;
            s_q.nbits <= '0;
            s_q.busy  <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign line = s_q.sh[0];
    assign busy = s_q.busy;
endmodule

// File: rtl/sertx_irq_gen.sv
module sertx_irq_gen (
    input  logic empty,
    input  logic done,
    input  logic empty_en,
    input  logic done_en,
    output logic req
);
    always_comb begin
        req = (empty && empty_en) || (done && done_en);
    end
endmodule

// File: rtl/sertx_unit.sv
module sertx_unit
    import sertx_pkg::*;
#(
    parameter int DATA_W = SERTX_DATA_W,
    localparam int FW    = DATA_W + 3,
    localparam int CW    = $clog2(DATA_W + 4)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              tx_en,
    input  logic              len9,
    input  logic              bit9,
    input  logic              irq_empty_en,
    input  logic              irq_done_en,
    input  logic              bit_tick,
    output logic              txd,
    output logic              flag_empty,
    output logic              flag_done,
    output logic              irq
);
    sertx_flags_t      f_d, f_q;
    logic [DATA_W-1:0] hold_d, hold_q;

    logic              accept;
    logic              have_byte;
    logic [DATA_W-1:0] next_byte;
    logic              start;
    logic              busy;
    logic              frame_end;
    logic [FW-1:0]     word;
    logic [CW-1:0]     nbits;

    always_comb begin
        accept    = wr_en && f_q.empty;
        have_byte = accept || f_q.pend;
        next_byte = accept ? wr_data : hold_q;
        start     = tx_en && have_byte && (!busy || frame_end);

        f_d    = f_q;
        hold_d = hold_q;
        if (accept) begin
            f_d.pend = 1'b1;
            hold_d   = wr_data;
        end
        if (start) begin
            f_d.pend  = 1'b0;
            f_d.empty = 1'b0;
            f_d.done  = 1'b0;
        end else if (frame_end) begin
            f_d.empty = 1'b1;
            f_d.done  = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            f_q.empty <= 1'b1;
            f_q.done  <= 1'b1;
            f_q.pend  <= 1'b0;
            hold_q    <= '0;
        end else begin
            f_q    <= f_d;
            hold_q <= hold_d;
        end
    end

    sertx_frame_pack #(.DATA_W(DATA_W)) pack_i (
        .data  (next_byte),
        .len9  (len9),
        .bit9  (bit9),
        .word  (word),
        .nbits (nbits)
    );

    sertx_shifter #(.DATA_W(DATA_W)) shift_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (start),
        .load_word  (word),
        .load_nbits (nbits),
        .tick       (bit_tick),
        .line       (txd),
        .busy       (busy),
        .frame_end  (frame_end)
    );

    sertx_irq_gen irq_i (
        .empty    (f_q.empty),
        .done     (f_q.done),
        .empty_en (irq_empty_en),
        .done_en  (irq_done_en),
        .req      (irq)
    );

    assign flag_empty = f_q.empty;
    assign flag_done  = f_q.done;
endmodule

// File: rtl/sertx_unit_chk.sv
module sertx_unit_chk (
    input logic clk,
    input logic rst_n,
    input logic wr_en,
    input logic tx_en,
    input logic bit_tick,
    input logic txd,
    input logic flag_empty,
    input logic flag_done,
    input logic irq
);
    p_flag_pair_r4: assert property (@(posedge clk) disable iff (!rst_n)
        flag_empty == flag_done);

    p_start_now_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && flag_empty && tx_en) |=> (!flag_empty && !txd));

    p_idle_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
        flag_empty |-> txd);

    p_hold_between_ticks_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag_empty && !bit_tick) |=> (!flag_empty && $stable(txd)));

    p_end_on_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_empty) |-> $past(bit_tick));

    p_quiet_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_empty |-> !irq);
endmodule

bind sertx_unit sertx_unit_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .tx_en      (tx_en),
    .bit_tick   (bit_tick),
    .txd        (txd),
    .flag_empty (flag_empty),
    .flag_done  (flag_done),
    .irq        (irq)
);

// File: tb/sertx_unit_tb_top.sv
module sertx_unit_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       tx_en = 1'b0;
    logic       len9 = 1'b0;
    logic       bit9 = 1'b0;
    logic       irq_empty_en = 1'b0;
    logic       irq_done_en = 1'b0;
    logic       bit_tick = 1'b0;
    logic       txd;
    logic       flag_empty;
    logic       flag_done;
    logic       irq;

    int checks = 0;
    int failures = 0;

    always #10 clk = ~clk;

    sertx_unit dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (wr_en),
        .wr_data      (wr_data),
        .tx_en        (tx_en),
        .len9         (len9),
        .bit9         (bit9),
        .irq_empty_en (irq_empty_en),
        .irq_done_en  (irq_done_en),
        .bit_tick     (bit_tick),
        .txd          (txd),
        .flag_empty   (flag_empty),
        .flag_done    (flag_done),
        .irq          (irq)
    );

    function automatic logic exp_bit(input logic [7:0] d, input logic l9,
                                     input logic b9, input int k);
        if (k == 0) return 1'b0;
        if (k <= 8) return d[k-1];
        if (k == 9) return l9 ? b9 : 1'b1;
        return 1'b1;
    endfunction

    function automatic logic exp_irq(input logic e, input logic c,
                                     input logic ee, input logic ce);
        return (e && ee) || (c && ce);
    endfunction

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    task automatic cycle();
        @(posedge clk);
        #1;
    endtask

    task automatic chk_flags(input string req, input logic exp);
        chk({req, " flag_empty"}, flag_empty, exp);
        chk({req, " flag_done"}, flag_done, exp);
        chk("R8 irq", irq, exp_irq(flag_empty, flag_done, irq_empty_en, irq_done_en));
    endtask

    // run ticks on an idle line and expect it to stay idle
    task automatic idle_ticks(input string req, input int n);
        for (int i = 0; i < n; i++) begin
            bit_tick = 1'b1;
            cycle();
            bit_tick = 1'b0;
            cycle();
            chk_flags(req, 1'b1);
            chk({req, " R9 txd idle"}, txd, 1'b1);
        end
    endtask

    // frame has just started; walk it bit by bit
    // junk_at: -1 none, 0 during a gap, 1 on the final tick
    task automatic walk_frame(input logic [7:0] d, input logic l9, input logic b9,
                              input int gap, input int junk_at);
        int nb = l9 ? 11 : 10;
        chk_flags("R3 start", 1'b0);
        bit9 = ~b9; // ninth bit must be the value captured at start (R6)
        for (int k = 0; k < nb; k++) begin
            chk($sformatf("R6 bit %0d", k), txd, exp_bit(d, l9, b9, k));
            for (int g = 0; g < gap - 1; g++) begin
                if (junk_at == 0 && g == 0) begin
                    wr_en = 1'b1;
                    wr_data = ~d;
                end
                cycle();
                wr_en = 1'b0;
                chk("R5 hold txd", txd, exp_bit(d, l9, b9, k));
                chk_flags("R5 busy", 1'b0);
            end
            if (junk_at == 1 && k == nb - 1) begin
                wr_en = 1'b1;
                wr_data = ~d;
            end
            bit_tick = 1'b1;
            cycle();
            bit_tick = 1'b0;
            wr_en = 1'b0;
            if (k == nb - 1) begin
                chk_flags("R5 end", 1'b1);
                chk("R9 txd after", txd, 1'b1);
            end else begin
                chk_flags("R5 mid", 1'b0);
            end
        end
    endtask

    task automatic send(input logic [7:0] d, input logic l9, input logic b9,
                        input int gap, input int junk_at);
        len9 = l9;
        bit9 = b9;
        wr_en = 1'b1;
        wr_data = d;
        cycle();
        wr_en = 1'b0;
        chk("R3 start bit", txd, 1'b0);
        walk_frame(d, l9, b9, gap, junk_at);
        if (junk_at >= 0) idle_ticks("R2 ignored write", 12);
    endtask

    task automatic run_all();
        void'($urandom(32'h1234_5678));
        repeat (3) cycle();
        rst_n = 1'b1;
        cycle();
        // R1 reset state
        chk_flags("R1 reset", 1'b1);
        chk("R1 txd", txd, 1'b1);
        irq_empty_en = 1'b1;
        #1;
        chk("R8 irq empty en", irq, 1'b1);
        irq_empty_en = 1'b0;
        irq_done_en = 1'b0;
        #1;
        chk("R8 irq off", irq, 1'b0);
        tx_en = 1'b1;
        idle_ticks("R1 nothing pending", 12);

        // directed 8-bit and 9-bit frames
        send(8'hA5, 1'b0, 1'b0, 2, -1);
        send(8'h3C, 1'b1, 1'b1, 3, 0);
        send(8'h81, 1'b1, 1'b0, 1, 1);

        // R7 pending while disabled, overwrite, then enable
        tx_en = 1'b0;
        wr_en = 1'b1;
        wr_data = 8'h5A;
        cycle();
        wr_en = 1'b0;
        chk_flags("R7 pending", 1'b1);
        chk("R7 txd idle", txd, 1'b1);
        idle_ticks("R7 held", 3);
        wr_en = 1'b1;
        wr_data = 8'hC3;
        cycle();
        wr_en = 1'b0;
        chk_flags("R7 overwrite", 1'b1);
        len9 = 1'b0;
        tx_en = 1'b1;
        cycle();
        chk("R7 start bit", txd, 1'b0);
        walk_frame(8'hC3, 1'b0, 1'b0, 2, -1);
        idle_ticks("R7 single send", 12);

        // random frames
        for (int n = 0; n < 40; n++) begin
            logic [7:0] d = 8'($urandom);
            logic l9 = 1'($urandom);
            logic b9 = 1'($urandom);
            int gap = 1 + int'($urandom % 4);
            int junk = int'($urandom % 3) - 1;
            irq_empty_en = 1'($urandom);
            irq_done_en = 1'($urandom);
            send(d, l9, b9, gap, junk);
            repeat (int'($urandom % 3)) cycle();
        end
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (150000) @(posedge clk);
                failures++;
                $display("FAIL watchdog expired actual=running expected=done");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule